// File: doc/BRIEF.md
# Hierarchical Active-Vertex Bit Vector

This block records which vertices of a graph must be processed in the next pass of an iterative algorithm, and hands them back one at a time in the pass after that. It holds two banks with one bit per vertex. Insertions set bits in the bank that is being filled. The other bank is drained in ascending vertex order over a valid/ready stream. A swap command exchanges the two roles at each iteration boundary.

Each bank also holds two summary levels above the per-vertex bits. A top word has one bit per large region. A middle level has one bit per 32-vertex word. Extraction follows the lowest set bit down through the three levels, so empty regions cost no cycles. A vertex's bit is cleared as it is handed out, and a summary bit is cleared when the last bit below it goes. A drained bank is therefore empty when it returns to the filling role. With word width W, the block tracks W³ vertices; W=32 gives 32768.

Top module: `active_vertex_tracker`

## Requirements
- R1: After reset both banks are empty: `out_valid` is 0 and `list_done` is 1.
- R2: An insertion sets its vertex's bit in the filling bank in one cycle. It does not appear on the output stream until a swap has been accepted.
- R3: After a swap, the stream delivers every inserted vertex ID exactly once, in strictly increasing order. One ID is transferred per cycle in which `out_valid` and `out_ready` are both high.
- R4: Inserting a vertex that is already set has no further effect: its ID is delivered only once.
- R5: `out_last` is high exactly on the final ID of the list. After that ID is transferred, `out_valid` is 0 and `list_done` is 1.
- R6: A swap request made while `list_done` is 0 is ignored. The current list keeps streaming unchanged.
- R7: Bits are cleared as they are delivered. A bank that becomes the filling bank again therefore carries no IDs from earlier iterations.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_id` holds its value.
- R9: An insertion made in the same cycle as an accepted swap goes to the bank that becomes the drained bank. It is delivered in the list that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insertion request |
| ins_id | input | 3·log2(W) | Vertex ID to mark active for the next iteration |
| swap_req | input | 1 | Iteration boundary; accepted only when `list_done` is 1 |
| out_valid | output | 1 | An active vertex ID is presented |
| out_ready | input | 1 | Consumer accepts the presented ID |
| out_id | output | 3·log2(W) | Lowest remaining active vertex ID |
| out_last | output | 1 | The presented ID is the final one of the list |
| list_done | output | 1 | The bank being drained is empty |

## Verification
The assertions take for granted that `ins_id` is below W³. They also assume the consumer may stall at any time, and that swaps may be requested at any time. The ascending-order property assumes that nothing refills the drained bank between transfers, and the block's structure guarantees this. The stimulus only drives legal IDs and toggles `out_ready` on a fixed pattern. It deliberately issues a swap in the middle of a list, and insertions are fed during the drain and in the swap cycle itself, so every concurrent case the properties cover is reached.

// File: rtl/avt_pkg.sv
package avt_pkg;

  // Index of the lowest set bit; 0 when nothing is set.
  function automatic int unsigned lowest_set(input logic [63:0] x);
    int unsigned idx;
    idx = 0;
    for (int i = 63; i >= 0; i--) begin
      if (x[i]) idx = i;
    end
    return idx;
  endfunction

  // True when exactly one bit is set.
  function automatic logic single_bit(input logic [63:0] x);
    return (x != 64'd0) && ((x & (x - 64'd1)) == 64'd0);
  endfunction

endpackage

// File: rtl/avt_bank.sv
module avt_bank
  import avt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   set_en,
  input  logic [3*$clog2(W)-1:0] set_id,
  input  logic                   pop_en,
  output logic                   nonempty,
  output logic [3*$clog2(W)-1:0] head_id,
  output logic                   head_last
);
  localparam int LW     = $clog2(W);
  localparam int IDW    = 3 * LW;
  localparam int LEAVES = W * W;

  logic [W-1:0] top_q;
  logic [W-1:0] mid_q  [W];
  logic [W-1:0] leaf_q [LEAVES];

  // head search: lowest region, then lowest word, then lowest vertex
  logic [LW-1:0]   hd_top, hd_mid, hd_bit;
  logic [2*LW-1:0] hd_leaf;
  logic            leaf_drop, mid_drop;

  always_comb begin
    hd_top    = LW'(lowest_set(64'(top_q)));
    hd_mid    = LW'(lowest_set(64'(mid_q[hd_top])));
    hd_leaf   = {hd_top, hd_mid};
    hd_bit    = LW'(lowest_set(64'(leaf_q[hd_leaf])));
    leaf_drop = single_bit(64'(leaf_q[hd_leaf]));
    mid_drop  = leaf_drop && single_bit(64'(mid_q[hd_top]));
    nonempty  = (top_q != '0);
    head_id   = {hd_top, hd_mid, hd_bit};
    head_last = mid_drop && single_bit(64'(top_q));
  end

  // insertion address fields
  logic [LW-1:0]   st_top, st_mid, st_bit;
  logic [2*LW-1:0] st_leaf;
  assign st_top  = set_id[IDW-1:2*LW];
  assign st_mid  = set_id[2*LW-1:LW];
  assign st_bit  = set_id[LW-1:0];
  assign st_leaf = set_id[IDW-1:LW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= '0;
      for (int i = 0; i < W; i++) mid_q[i] <= '0;
      for (int i = 0; i < LEAVES; i++) leaf_q[i] <= '0;
    end else begin
      if (set_en) begin
        leaf_q[st_leaf][st_bit] <= 1'b1;
        mid_q[st_top][st_mid]   <= 1'b1;
        top_q[st_top]           <= 1'b1;
      end
      if (pop_en) begin
        leaf_q[hd_leaf][hd_bit] <= 1'b0;
        if (leaf_drop) mid_q[hd_top][hd_mid] <= 1'b0;
        if (mid_drop)  top_q[hd_top] <= 1'b0;
      end
    end
  end

  assert_pop_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |-> nonempty);

  assert_set_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> nonempty);

endmodule

// File: rtl/active_vertex_tracker.sv
module active_vertex_tracker #(
  parameter int W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ins_valid,
  input  logic [3*$clog2(W)-1:0] ins_id,
  input  logic                   swap_req,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [3*$clog2(W)-1:0] out_id,
  output logic                   out_last,
  output logic                   list_done
);
  localparam int IDW = 3 * $clog2(W);

  logic           fill_sel_q;   // bank receiving insertions
  logic           drain_sel;
  logic           out_fire, swap_take;
  logic           bk_nonempty [2];
  logic [IDW-1:0] bk_head     [2];
  logic           bk_last     [2];

  assign drain_sel = ~fill_sel_q;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    avt_bank #(.W(W)) bank_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (ins_valid && (fill_sel_q == 1'(b))),
      .set_id   (ins_id),
      .pop_en   (out_fire && (drain_sel == 1'(b))),
      .nonempty (bk_nonempty[b]),
      .head_id  (bk_head[b]),
      .head_last(bk_last[b])
    );
  end

  assign out_valid = bk_nonempty[drain_sel];
  assign out_id    = bk_head[drain_sel];
  assign out_last  = bk_last[drain_sel];
  assign list_done = !bk_nonempty[drain_sel];
  assign out_fire  = out_valid && out_ready;
  assign swap_take = swap_req && list_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_sel_q <= 1'b0;
    else if (swap_take) fill_sel_q <= ~fill_sel_q;
  end

  // observation registers for the ordering property
  logic [IDW-1:0] prev_id_q;
  logic           have_prev_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_id_q   <= '0;
      have_prev_q <= 1'b0;
    end else if (swap_take) begin
      have_prev_q <= 1'b0;
    end else if (out_fire) begin
      prev_id_q   <= out_id;
      have_prev_q <= 1'b1;
    end
  end

  assert_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && have_prev_q) |-> (out_id > prev_id_q));

  assert_last_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && out_last) |=> list_done);

  assert_swap_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_req && !list_done) |=> (fill_sel_q == $past(fill_sel_q)));

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_id)));

endmodule

// File: tb/active_vertex_tracker_tb_top.sv
module active_vertex_tracker_tb_top;
  localparam int W   = 4;
  localparam int IDW = 6;
  localparam int NV  = 64;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 8 ns period

  logic           rst_n, ins_valid, swap_req, out_ready;
  logic [IDW-1:0] ins_id;
  logic           out_valid, out_last, list_done;
  logic [IDW-1:0] out_id;

  active_vertex_tracker #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_id(ins_id),
    .swap_req(swap_req), .out_valid(out_valid), .out_ready(out_ready),
    .out_id(out_id), .out_last(out_last), .list_done(list_done)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  int r9_vtx = -1;
  bit cur_map [NV];
  bit nxt_map [NV];
  int pend [$];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic bit pat(input int p, input int v);
    case (p)
      0: return (v % 5) == 1;
      1: return 1'b1;
      2: return 1'b0;
      3: return v == 0;
      4: return v == NV - 1;
      5: return ((v % 7) == 0) || (v >= 60);
      default: return ((v * 37 + 11) % NV) < 20;
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic drain();
    int exp_ids [$];
    int cnt, pos, cyc;
    bit prev_stall, prev_swap;
    int prev_id;
    for (int v = 0; v < NV; v++) if (cur_map[v]) exp_ids.push_back(v);
    cnt = exp_ids.size();
    pos = 0; cyc = 0; prev_stall = 0; prev_swap = 0; prev_id = 0;
    while (pos < cnt || pend.size() > 0) begin
      @(negedge clk);
      if (prev_stall) chk(out_valid && int'(out_id) == prev_id, "R8", int'(out_id), prev_id);
      if (prev_swap) chk(out_valid == 1'b1, "R6", int'(out_valid), 1);
      if (pos < cnt) begin
        chk(out_valid && int'(out_id) == exp_ids[pos],
            (exp_ids[pos] == r9_vtx) ? "R9" : "R3", int'(out_id), exp_ids[pos]);
        chk(out_last == (pos == cnt - 1), "R5", int'(out_last), int'(pos == cnt - 1));
      end else begin
        chk(out_valid == 1'b0, "R2", int'(out_valid), 0);
      end
      out_ready  = (cyc % 3) != 2;
      prev_stall = !out_ready && (pos < cnt);
      prev_id    = int'(out_id);
      if (out_ready && pos < cnt) pos++;
      swap_req  = (cyc == 1) && (cnt >= 3);   // R6: must be ignored
      prev_swap = swap_req;
      if (pend.size() > 0) begin
        ins_valid = 1'b1;
        ins_id    = IDW'(pend.pop_front());
      end else begin
        ins_valid = 1'b0;
      end
      cyc++;
    end
    @(negedge clk);
    out_ready = 1'b0; ins_valid = 1'b0; swap_req = 1'b0;
    chk(out_valid == 1'b0, "R4 R7 no extra ID", int'(out_valid), 0);
    chk(list_done == 1'b1, "R5 list_done", int'(list_done), 1);
  endtask

  task automatic swap_over(input int extra);
    @(negedge clk);
    swap_req = 1'b1;
    if (extra >= 0) begin   // R9: insertion in the swap cycle
      ins_valid = 1'b1;
      ins_id    = IDW'(extra);
      nxt_map[extra] = 1'b1;
      r9_vtx = extra;
    end else begin
      ins_valid = 1'b0;
      r9_vtx = -1;
    end
    cur_map = nxt_map;
    for (int v = 0; v < NV; v++) nxt_map[v] = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; ins_valid = 1'b0; ins_id = '0; swap_req = 1'b0; out_ready = 1'b0;
    for (int v = 0; v < NV; v++) begin cur_map[v] = 1'b0; nxt_map[v] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(list_done == 1'b1, "R1 list_done", int'(list_done), 1);
    for (int p = 0; p < 7; p++) begin
      pend.delete();
      for (int v = NV - 1; v >= 0; v--) if (pat(p, v)) pend.push_back(v);
      for (int v = 0; v < NV; v++) if (pat(p, v) && (v % 2 == 0)) pend.push_back(v); // R4 repeats
      for (int v = 0; v < NV; v++) nxt_map[v] = pat(p, v);
      drain();
      swap_over((p % 2 == 1) ? (p * 9 + 3) % NV : -1);
    end
    pend.delete();
    drain();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule